// File: doc/BRIEF.md
# Strobe-Paced Interpolating FIR with Bypass

This block is one channel of a transmit-side interpolation stage in which the sample source and the filter share a single clock. There is no ready/valid handshake. An internal rate generator produces a one-cycle strobe once every `RATE` clocks. The strobe sets the pace at which input samples are taken in and at which filtered samples are offered downstream. A sample is taken in only when the strobe and the source's valid are high together. A strobe that arrives while valid is low feeds a zero into the filter history, which inserts zeros between the real samples.

The data bus carries `LANES` lanes of 16-bit signed samples with 15 fractional bits. Each lane has its own history and multiply-accumulate over `TAPS` fixed signed 16-bit integer coefficients. The sum is scaled down by `2^SHIFT`, rounded to the nearest value with halves going toward zero, and clamped to 16 bits.

A single `active` input controls the whole block. When it is high, the rate generator runs and the filtered path drives the outputs. When it is low, the rate generator and every lane's history are held cleared, and valid, enable and data pass straight from input to output. The enable signal passes through unchanged in both modes.

Top module: `ifir_interp`

## Requirements
- R1: While `active` is high, the internal strobe is high for exactly one clock in every `RATE` clocks. Its first high cycle is the `RATE`-th cycle in which `active` is high. While `active` is low, the strobe stays low and its phase is held at the start.
- R2: With `active` high, `out_valid` equals the strobe in every cycle, whatever the level of `in_valid`.
- R3: A lane sample enters the filter history only on a clock where the strobe and `in_valid` are both high. A strobe with `in_valid` low enters the value 0. `in_data` and `in_valid` between strobes have no effect on later outputs.
- R4: At each strobe, every lane computes `acc = sum over k of C[k]*x[k]`. Here `x[0]` is the value entered at this strobe, `x[k]` is the value entered `k` strobes earlier, and `C[k]` is bits `[16k+15:16k]` of `COEFS`. The result is shown on `out_data` from the next cycle until the next strobe, so it is the value seen during the following strobe cycle. It holds steady between strobes.
- R5: Scaling rounds `acc / 2^SHIFT` to the nearest integer, with exact halves rounded toward zero. For example, with `SHIFT`=15, +0.5 and -0.5 both give 0, and +1.5 gives 1 while -1.5 gives -1.
- R6: A rounded value above 32767 is output as 32767. A rounded value below -32768 is output as -32768.
- R7: Lane `l` occupies bits `[16l+15:16l]` of `in_data` and `out_data`. Lanes are filtered independently with the same coefficients.
- R8: With `active` low, `out_valid` equals `in_valid` and `out_data` equals `in_data` in the same cycle.
- R9: `out_enable` equals `in_enable` in every cycle, in both modes.
- R10: While `active` is low, every lane's history and held result are cleared. After `active` rises again, the outputs up to and including the first strobe are 0, and later outputs depend only on samples taken after the rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by source, filter and sink |
| rst_n | input | 1 | Asynchronous active-low reset |
| active | input | 1 | 1: filtered mode with rate generator running; 0: bypass and clear |
| in_valid | input | 1 | Source sample valid |
| in_enable | input | 1 | Channel enable from the source |
| in_data | input | 16*LANES | Input lanes, signed 16-bit each |
| out_valid | output | 1 | Strobe in filtered mode, `in_valid` in bypass |
| out_enable | output | 1 | Copy of `in_enable` |
| out_data | output | 16*LANES | Filtered or bypassed lanes |

## Verification
The bench builds the block with `RATE`=4, `LANES`=2, `TAPS`=4 and `SHIFT`=15. The coefficients are 16384, -8192, 32767 and 4096 for k = 0 to 3. Their positive sum is well above unity gain, so full-scale inputs drive both saturation limits. The coefficient of one half on the newest sample turns small odd inputs into exact rounding ties of both signs. The short period gives many strobes with and without valid, and toggling `active` exercises clearing and bypass repeatedly.

// File: rtl/ifir_pkg.sv
package ifir_pkg;
  localparam int unsigned SMP_W  = 16;
  localparam int unsigned COEF_W = 16;
  typedef logic signed [SMP_W-1:0] smp_t;
endpackage

// File: rtl/ifir_strobe_gen.sv
module ifir_strobe_gen #(
  parameter int unsigned RATE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic strobe
);
  localparam int unsigned CNT_W = (RATE > 2) ? $clog2(RATE) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RATE - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_last;

  assign at_last = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!run) begin
      cnt_d = '0;
    end else if (at_last) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign strobe = run & at_last;
endmodule

// File: rtl/ifir_lane.sv
module ifir_lane
  import ifir_pkg::*;
#(
  parameter int unsigned TAPS  = 4,
  parameter int unsigned SHIFT = 15,
  parameter logic [TAPS*COEF_W-1:0] COEFS = {TAPS{16'sd4096}}
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic step,
  input  logic admit,
  input  smp_t smp_in,
  output smp_t smp_out
);
  localparam int unsigned ACC_W = 2*SMP_W + $clog2(TAPS) + 1;
  localparam logic signed [ACC_W:0] HALF = (ACC_W+1)'(1) << (SHIFT-1);
  localparam logic signed [ACC_W:0] POS_LIM = (ACC_W+1)'(32767);
  localparam logic signed [ACC_W:0] NEG_LIM = -(ACC_W+1)'(32768);

  smp_t hist_q [TAPS];
  smp_t hist_d [TAPS];
  smp_t shifted [TAPS];
  smp_t res_q, res_d;

  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W:0]   biased;
  logic signed [ACC_W:0]   scaled;
  smp_t                    clamped;

  // history as it becomes after this strobe: a zero when not admitted
  always_comb begin
    shifted[0] = admit ? smp_in : '0;
    for (int k = 1; k < TAPS; k++) begin
      shifted[k] = hist_q[k-1];
    end
  end

  always_comb begin
    logic signed [ACC_W-1:0] ce;
    logic signed [ACC_W-1:0] xe;
    acc = '0;
    for (int k = 0; k < TAPS; k++) begin
      ce  = {{(ACC_W-COEF_W){COEFS[k*COEF_W+COEF_W-1]}}, COEFS[k*COEF_W +: COEF_W]};
      xe  = {{(ACC_W-SMP_W){shifted[k][SMP_W-1]}}, shifted[k]};
      acc = acc + ce * xe;
    end
  end

  // nearest, halves toward zero, then clamp
  always_comb begin
    biased = {acc[ACC_W-1], acc} + (acc[ACC_W-1] ? HALF : (HALF - (ACC_W+1)'(1)));
    scaled = biased >>> SHIFT;
    if (scaled > POS_LIM) begin
      clamped = 16'sh7FFF;
    end else if (scaled < NEG_LIM) begin
      clamped = 16'sh8000;
    end else begin
      clamped = scaled[SMP_W-1:0];
    end
  end

  always_comb begin
    hist_d = hist_q;
    res_d  = res_q;
    if (!run) begin
      for (int k = 0; k < TAPS; k++) hist_d[k] = '0;
      res_d = '0;
    end else if (step) begin
      hist_d = shifted;
      res_d  = clamped;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < TAPS; k++) hist_q[k] <= '0;
      res_q <= '0;
    end else begin
      hist_q <= hist_d;
      res_q  <= res_d;
    end
  end

  assign smp_out = res_q;
endmodule

// File: rtl/ifir_out_sel.sv
module ifir_out_sel #(
  parameter int unsigned W = 32
) (
  input  logic         use_filt,
  input  logic         byp_valid,
  input  logic [W-1:0] byp_data,
  input  logic         flt_valid,
  input  logic [W-1:0] flt_data,
  output logic         sel_valid,
  output logic [W-1:0] sel_data
);
  always_comb begin
    if (use_filt) begin
      sel_valid = flt_valid;
      sel_data  = flt_data;
    end else begin
      sel_valid = byp_valid;
      sel_data  = byp_data;
    end
  end
endmodule

// File: rtl/ifir_interp.sv
module ifir_interp
  import ifir_pkg::*;
#(
  parameter int unsigned RATE  = 4,
  parameter int unsigned LANES = 2,
  parameter int unsigned TAPS  = 4,
  parameter int unsigned SHIFT = 15,
  parameter logic [TAPS*COEF_W-1:0] COEFS = {TAPS{16'sd4096}}
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   active,
  input  logic                   in_valid,
  input  logic                   in_enable,
  input  logic [LANES*SMP_W-1:0] in_data,
  output logic                   out_valid,
  output logic                   out_enable,
  output logic [LANES*SMP_W-1:0] out_data
);
  localparam int unsigned BUS_W = LANES * SMP_W;

  logic             strobe;
  logic             admit;
  logic [BUS_W-1:0] filt_data;

  ifir_strobe_gen #(.RATE(RATE)) strobe_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (active),
    .strobe (strobe)
  );

  assign admit = strobe & in_valid;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    smp_t lane_out;
    ifir_lane #(.TAPS(TAPS), .SHIFT(SHIFT), .COEFS(COEFS)) lane_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (active),
      .step    (strobe),
      .admit   (admit),
      .smp_in  (in_data[l*SMP_W +: SMP_W]),
      .smp_out (lane_out)
    );
    assign filt_data[l*SMP_W +: SMP_W] = lane_out;
  end

  ifir_out_sel #(.W(BUS_W)) sel_i (
    .use_filt  (active),
    .byp_valid (in_valid),
    .byp_data  (in_data),
    .flt_valid (strobe),
    .flt_data  (filt_data),
    .sel_valid (out_valid),
    .sel_data  (out_data)
  );

  assign out_enable = in_enable;
endmodule

// File: rtl/ifir_interp_chk.sv
module ifir_interp_chk #(
  parameter int unsigned RATE  = 4,
  parameter int unsigned BUS_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             active,
  input logic             in_valid,
  input logic             in_enable,
  input logic [BUS_W-1:0] in_data,
  input logic             out_valid,
  input logic             out_enable,
  input logic [BUS_W-1:0] out_data,
  input logic             strobe
);
  localparam int unsigned GW = $clog2(RATE) + 1;
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '0;
    end else if (!active || strobe) begin
      gap_q <= '0;
    end else begin
      gap_q <= gap_q + GW'(1);
    end
  end

  // R1
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> (gap_q == GW'(RATE - 1)));

  // R1
  strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !strobe);

  // R2
  single_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && out_valid) |=> !(active && out_valid));

  // R4
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !$past(strobe)) |-> $stable(out_data));

  // R8
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (out_valid == in_valid && out_data == in_data));

  // R9
  enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_enable == in_enable);
endmodule

bind ifir_interp ifir_interp_chk #(.RATE(RATE), .BUS_W(LANES*16)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .active     (active),
  .in_valid   (in_valid),
  .in_enable  (in_enable),
  .in_data    (in_data),
  .out_valid  (out_valid),
  .out_enable (out_enable),
  .out_data   (out_data),
  .strobe     (strobe)
);

// File: tb/ifir_interp_tb_top.sv
`timescale 1ns/1ps
module ifir_interp_tb_top;
  localparam int RATE  = 4;
  localparam int LANES = 2;
  localparam int TAPS  = 4;
  localparam int SHIFT = 15;
  localparam int BW    = LANES*16;

  int cf [TAPS] = '{16384, -8192, 32767, 4096};

  logic          clk = 1'b0;
  logic          rst_n;
  logic          active, in_valid, in_enable;
  logic [BW-1:0] in_data;
  logic          out_valid, out_enable;
  logic [BW-1:0] out_data;

  always #2 clk = ~clk;

  ifir_interp #(
    .RATE(RATE), .LANES(LANES), .TAPS(TAPS), .SHIFT(SHIFT),
    .COEFS({16'h1000, 16'h7FFF, 16'hE000, 16'h4000})
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .active(active), .in_valid(in_valid),
    .in_enable(in_enable), .in_data(in_data), .out_valid(out_valid),
    .out_enable(out_enable), .out_data(out_data)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  string tag = "R4";
  int    since_rise = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int round_sat(input longint acc);
    longint half, q;
    half = longint'(1) << (SHIFT-1);
    if (acc >= 0) q = (acc + half - 1) / (longint'(1) << SHIFT);
    else          q = -((-acc + half - 1) / (longint'(1) << SHIFT));
    if (q > 32767)  q = 32767;
    if (q < -32768) q = -32768;
    return int'(q);
  endfunction

  // scoreboard state
  int mcnt;
  int hist [LANES][TAPS];
  int cur  [LANES];
  int expq [$];

  always @(negedge clk) begin
    if (!rst_n) begin
      mcnt = 0;
      foreach (hist[l, k]) hist[l][k] = 0;
      foreach (cur[l]) cur[l] = 0;
      expq.delete();
    end else begin
      bit pulse;
      pulse = active && (mcnt == RATE-1);
      chk(out_enable == in_enable, "R9", out_enable, in_enable);
      if (!active) begin
        chk(out_valid == in_valid, "R8", out_valid, in_valid);
        chk(out_data == in_data, "R8", out_data, in_data);
        mcnt = 0;
        foreach (hist[l, k]) hist[l][k] = 0;
        foreach (cur[l]) cur[l] = 0;
        expq.delete();
      end else begin
        chk(out_valid == pulse, pulse ? "R1" : "R2", out_valid, pulse);
        for (int l = 0; l < LANES; l++) begin
          int got;
          got = int'($signed(out_data[16*l +: 16]));
          chk(got == cur[l], (l == 0) ? tag : "R7", got, cur[l]);
        end
        if (pulse) begin
          for (int l = 0; l < LANES; l++) begin
            longint acc;
            for (int k = TAPS-1; k > 0; k--) hist[l][k] = hist[l][k-1];
            hist[l][0] = in_valid ? int'($signed(in_data[16*l +: 16])) : 0;
            acc = 0;
            for (int k = 0; k < TAPS; k++) acc += longint'(cf[k]) * hist[l][k];
            expq.push_back(round_sat(acc));
          end
          for (int l = 0; l < LANES; l++) cur[l] = expq.pop_front();
          mcnt = 0;
        end else begin
          mcnt++;
        end
      end
    end
  end

  task automatic drive(input bit a, input bit v, input bit e, input int d0, input int d1);
    active    = a;
    in_valid  = v;
    in_enable = e;
    in_data   = {16'(d1), 16'(d0)};
    @(posedge clk);
    #1;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 50000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 50000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    active = 1'b1; in_valid = 1'b1; in_enable = 1'b1; in_data = 32'h1234_5678;
    repeat (3) @(negedge clk);
    // reset state, filtered mode: no strobe, cleared result
    chk(out_valid == 1'b0, "R1", out_valid, 0);
    chk(out_data == '0, "R10", out_data, 0);
    active = 1'b0;
    @(negedge clk);
    chk(out_data == in_data, "R8", out_data, in_data);
    @(posedge clk); #1;
    rst_n = 1'b1;

    // bypass with varied inputs
    tag = "R8";
    for (int i = 0; i < 20; i++) drive(0, i[0], i[1], i*1111 - 9000, 7000 - i*313);

    // filtered, valid always high, ramp data
    tag = "R4";
    for (int i = 0; i < 48; i++) drive(1, 1, i[2], i*700 - 12000, 15000 - i*450);

    // valid sparse: strobes without valid insert zeros, off-strobe data ignored
    tag = "R3";
    for (int i = 0; i < 72; i++) drive(1, (i % 3) == 0, 1, (i*2311) % 30000 - 15000, -(i*977) % 20000);

    // clear on deactivation, then fresh history
    drive(0, 1, 1, 25000, 25000);
    drive(0, 1, 1, 25000, 25000);
    tag = "R10";
    for (int i = 0; i < 3*RATE; i++) drive(1, 1, 1, 100 + i, -100 - i);

    // rounding ties and near-ties
    tag = "R5";
    foreach (cf[j]) begin end
    for (int j = 0; j < 6; j++) begin
      int v;
      v = (j == 0) ? 1 : (j == 1) ? -1 : (j == 2) ? 3 : (j == 3) ? -3 : (j == 4) ? 5 : -5;
      drive(0, 0, 1, 0, 0);
      drive(0, 0, 1, 0, 0);
      for (int i = 0; i < RATE; i++) drive(1, 1, 1, v, -v);
      for (int i = 0; i < 2*RATE; i++) drive(1, 0, 1, 0, 0);
    end

    // saturation at both limits
    tag = "R6";
    for (int i = 0; i < 6*RATE; i++) drive(1, 1, 1, 32767, -32768);
    for (int i = 0; i < 6*RATE; i++) drive(1, 1, 0, -32768, 32767);
    for (int i = 0; i < 2*RATE; i++) drive(1, 0, 1, 0, 0);
    drive(0, 0, 0, 0, 0);
    drive(0, 1, 1, 4321, -4321);
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule